// File: doc/BRIEF.md
# Compact Format Operand Decoder

This block takes the 16-bit opcode halfword of a compact two-operand instruction, together with one 16-bit address constant per operand, the eight general register values and a width status bit. It classifies the operation by data type and size, splits out each operand's addressing mode and register, forms an effective address for each memory operand and produces the register write-backs that post-increment addressing requires. Results are registered and appear one cycle after the instruction is presented. The block does not execute operations or handle floating-point arithmetic. It also does not decode any other instruction layout.

The halfword is laid out, from the most significant bit down, as a 6-bit opcode, then operand A (2-bit mode, 3-bit register), then operand B (2-bit mode, 3-bit register). Operand B is evaluated after operand A. A register that A post-increments is therefore seen by B with its new value.

Top module: `cfmt_opdec`

## Requirements
- R1: The class is decoded from opcode bits [15:14] and [13]. 00 gives a byte operation (op_kind 0, op_bytes 1). 100 gives single-precision float (op_kind 3, op_bytes 4). 101 gives double-precision float (op_kind 4, op_bytes 8).
- R2: For opcode prefix 01, the `wide_sel` value presented with the instruction picks the width. A value of 0 gives halfword (op_kind 1, op_bytes 2) and 1 gives word (op_kind 2, op_bytes 4).
- R3: Opcode prefix 11 marks the instruction as outside the format. The block gives op_kind 5, op_bytes 0 and illegal 1, and asserts no write-back.
- R4: Mode 00 (register operand) gives an effective address of 0 and no write-back.
- R5: Mode 10 (register indirect) gives an effective address equal to the named register and no write-back.
- R6: Mode 11 (post-increment) gives an effective address equal to the named register. It writes the register field with the register value plus op_bytes.
- R7: Mode 01 with constant bit 15 clear gives an address of index + register 0 + constant[14:0], zero-extended, modulo 2^AW.
- R8: Mode 01 with constant bit 15 set gives an address of index + base + constant[11:0], where the base register number is constant[14:12]. A base number of 0 contributes 0, so with no index the address stays below 4096.
- R9: In mode 01 the register field names the index register, and a field of 0 means no index term.
- R10: Operand B's register reads, including register 0 and the base register, see operand A's post-increment. When both operands post-increment the same register, only operand B writes it, with the register value plus twice op_bytes.
- R11: All outputs are registered one cycle after `in_valid`. out_valid follows in_valid with that lag, and write-backs are asserted only when out_valid is 1.
- R12: During and straight after reset, out_valid and both write-back enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn_hw | input | 16 | Opcode halfword |
| const_a | input | CW | Address constant for operand A |
| const_b | input | CW | Address constant for operand B |
| wide_sel | input | 1 | Width status bit for opcode prefix 01 |
| rf_flat | input | 8*AW | Register values, register k at bits [k*AW +: AW] |
| out_valid | output | 1 | Decoded result valid |
| op_code | output | 6 | Opcode field |
| op_kind | output | 3 | Operation class code |
| op_bytes | output | 4 | Operand size in bytes |
| illegal | output | 1 | Opcode not in this format |
| mode_a | output | 2 | Operand A mode |
| reg_a | output | 3 | Operand A register field |
| mode_b | output | 2 | Operand B mode |
| reg_b | output | 3 | Operand B register field |
| ea_a | output | AW | Operand A effective address |
| ea_b | output | AW | Operand B effective address |
| wb_a_en | output | 1 | Operand A write-back enable |
| wb_a_reg | output | 3 | Operand A write-back register |
| wb_a_val | output | AW | Operand A write-back value |
| wb_b_en | output | 1 | Operand B write-back enable |
| wb_b_reg | output | 3 | Operand B write-back register |
| wb_b_val | output | AW | Operand B write-back value |

## Verification
The assertions assume that every input carries a known 0 or 1 value on each clock edge after reset. They also assume that in_valid is low throughout reset. The bench meets this by driving all inputs, including the register values and both constants, with defined values on every cycle. It holds in_valid at 0 until reset has been released. Random opcodes, modes, registers and constants cover every encoding, and directed cases target the sharing of one register by both operands and a base number of 0.

// File: rtl/cfmt_pkg.sv
package cfmt_pkg;

    // register file shape fixed by the 3-bit register fields
    localparam int REG_SEL_W = 3;
    localparam int NREG      = 1 << REG_SEL_W;

    // operand addressing modes
    localparam logic [1:0] AM_REG  = 2'b00;
    localparam logic [1:0] AM_IDX  = 2'b01;
    localparam logic [1:0] AM_IND  = 2'b10;
    localparam logic [1:0] AM_PINC = 2'b11;

    typedef enum logic [2:0] {
        KIND_BYTE   = 3'd0,
        KIND_HALF   = 3'd1,
        KIND_WORD   = 3'd2,
        KIND_SINGLE = 3'd3,
        KIND_DOUBLE = 3'd4,
        KIND_BAD    = 3'd5
    } opkind_e;

    // opcode halfword, most significant field first
    typedef struct packed {
        logic [5:0]           opc;
        logic [1:0]           mode_a;
        logic [REG_SEL_W-1:0] reg_a;
        logic [1:0]           mode_b;
        logic [REG_SEL_W-1:0] reg_b;
    } ophw_t;

endpackage

// File: rtl/cfmt_class_dec.sv
module cfmt_class_dec
    import cfmt_pkg::*;
(
    input  logic [5:0] opc,
    input  logic       wide_sel,
    output opkind_e    kind,
    output logic [3:0] nbytes,
    output logic       bad
);

    always_comb begin
        bad    = 1'b0;
        kind   = KIND_BAD;
        nbytes = 4'd0;
        unique case (opc[5:4])
            2'b00: begin
                kind   = KIND_BYTE;
                nbytes = 4'd1;
            end
            2'b01: begin
                kind   = wide_sel ? KIND_WORD : KIND_HALF;
                nbytes = wide_sel ? 4'd4 : 4'd2;
            end
            2'b10: begin
                kind   = opc[3] ? KIND_DOUBLE : KIND_SINGLE;
                nbytes = opc[3] ? 4'd8 : 4'd4;
            end
            default: begin
                bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cfmt_ea_unit.sv
module cfmt_ea_unit
    import cfmt_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [1:0]           mode,
    input  logic [REG_SEL_W-1:0] rsel,
    input  logic [CW-1:0]        konst,
    input  logic [NREG*AW-1:0]   rf,
    input  logic [3:0]           nbytes,
    output logic [AW-1:0]        ea,
    output logic                 wb_en,
    output logic [AW-1:0]        wb_val
);

    localparam int LONG_W  = CW - 1;
    localparam int SHORT_W = CW - 1 - REG_SEL_W;

    logic [REG_SEL_W-1:0] bsel;
    logic [AW-1:0]        r_sel;
    logic [AW-1:0]        r_base;
    logic [AW-1:0]        r_zero;
    logic [AW-1:0]        idx_term;
    logic [AW-1:0]        base_term;
    logic [AW-1:0]        disp;

    assign bsel = konst[CW-2 -: REG_SEL_W];

    always_comb begin
        r_sel  = rf[int'(rsel) * AW +: AW];
        r_base = rf[int'(bsel) * AW +: AW];
        r_zero = rf[AW-1:0];

        // a zero register field in indexed mode means no index term
        idx_term = (rsel != '0) ? r_sel : '0;

        if (!konst[CW-1]) begin
            base_term = r_zero;
            disp      = AW'(konst[LONG_W-1:0]);
        end else begin
            base_term = (bsel != '0) ? r_base : '0;
            disp      = AW'(konst[SHORT_W-1:0]);
        end

        unique case (mode)
            AM_REG:  ea = '0;
            AM_IDX:  ea = idx_term + base_term + disp;
            default: ea = r_sel;
        endcase

        wb_en  = (mode == AM_PINC);
        wb_val = r_sel + AW'(nbytes);
    end

endmodule

// File: rtl/cfmt_opdec.sv
module cfmt_opdec
    import cfmt_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [15:0]          insn_hw,
    input  logic [CW-1:0]        const_a,
    input  logic [CW-1:0]        const_b,
    input  logic                 wide_sel,
    input  logic [8*AW-1:0]      rf_flat,
    output logic                 out_valid,
    output logic [5:0]           op_code,
    output logic [2:0]           op_kind,
    output logic [3:0]           op_bytes,
    output logic                 illegal,
    output logic [1:0]           mode_a,
    output logic [2:0]           reg_a,
    output logic [1:0]           mode_b,
    output logic [2:0]           reg_b,
    output logic [AW-1:0]        ea_a,
    output logic [AW-1:0]        ea_b,
    output logic                 wb_a_en,
    output logic [2:0]           wb_a_reg,
    output logic [AW-1:0]        wb_a_val,
    output logic                 wb_b_en,
    output logic [2:0]           wb_b_reg,
    output logic [AW-1:0]        wb_b_val
);

    typedef struct packed {
        logic                 valid;
        logic [5:0]           opc;
        opkind_e              kind;
        logic [3:0]           nbytes;
        logic                 bad;
        logic [1:0]           mode_a;
        logic [REG_SEL_W-1:0] reg_a;
        logic [1:0]           mode_b;
        logic [REG_SEL_W-1:0] reg_b;
        logic [AW-1:0]        ea_a;
        logic [AW-1:0]        ea_b;
        logic                 wba_en;
        logic [AW-1:0]        wba_val;
        logic                 wbb_en;
        logic [AW-1:0]        wbb_val;
    } dec_st_t;

    ophw_t           hw;
    opkind_e         kind_w;
    logic [3:0]      nbytes_w;
    logic            bad_w;
    logic [AW-1:0]   ea_a_w;
    logic [AW-1:0]   ea_b_w;
    logic            wba_raw;
    logic            wbb_raw;
    logic [AW-1:0]   wba_val_w;
    logic [AW-1:0]   wbb_val_w;
    logic [NREG*AW-1:0] rf_b;
    dec_st_t         st_d;
    dec_st_t         st_q;

    assign hw = ophw_t'(insn_hw);

    cfmt_class_dec u_class (
        .opc      (hw.opc),
        .wide_sel (wide_sel),
        .kind     (kind_w),
        .nbytes   (nbytes_w),
        .bad      (bad_w)
    );

    cfmt_ea_unit #(.AW(AW), .CW(CW)) u_ea_a (
        .mode   (hw.mode_a),
        .rsel   (hw.reg_a),
        .konst  (const_a),
        .rf     (rf_flat),
        .nbytes (nbytes_w),
        .ea     (ea_a_w),
        .wb_en  (wba_raw),
        .wb_val (wba_val_w)
    );

    // operand B observes the register file after operand A's increment
    for (genvar k = 0; k < NREG; k++) begin : g_fwd
        assign rf_b[k*AW +: AW] = (wba_raw && (hw.reg_a == REG_SEL_W'(k)))
                                  ? wba_val_w : rf_flat[k*AW +: AW];
    end

    cfmt_ea_unit #(.AW(AW), .CW(CW)) u_ea_b (
        .mode   (hw.mode_b),
        .rsel   (hw.reg_b),
        .konst  (const_b),
        .rf     (rf_b),
        .nbytes (nbytes_w),
        .ea     (ea_b_w),
        .wb_en  (wbb_raw),
        .wb_val (wbb_val_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.opc     = hw.opc;
        st_d.kind    = kind_w;
        st_d.nbytes  = nbytes_w;
        st_d.bad     = bad_w;
        st_d.mode_a  = hw.mode_a;
        st_d.reg_a   = hw.reg_a;
        st_d.mode_b  = hw.mode_b;
        st_d.reg_b   = hw.reg_b;
        st_d.ea_a    = ea_a_w;
        st_d.ea_b    = ea_b_w;
        st_d.wba_val = wba_val_w;
        st_d.wbb_val = wbb_val_w;
        st_d.wbb_en  = in_valid && !bad_w && wbb_raw;
        // the later writer to a shared register wins
        st_d.wba_en  = in_valid && !bad_w && wba_raw
                       && !(wbb_raw && (hw.reg_b == hw.reg_a));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign op_code   = st_q.opc;
    assign op_kind   = st_q.kind;
    assign op_bytes  = st_q.nbytes;
    assign illegal   = st_q.bad;
    assign mode_a    = st_q.mode_a;
    assign reg_a     = st_q.reg_a;
    assign mode_b    = st_q.mode_b;
    assign reg_b     = st_q.reg_b;
    assign ea_a      = st_q.ea_a;
    assign ea_b      = st_q.ea_b;
    assign wb_a_en   = st_q.wba_en;
    assign wb_a_reg  = st_q.reg_a;
    assign wb_a_val  = st_q.wba_val;
    assign wb_b_en   = st_q.wbb_en;
    assign wb_b_reg  = st_q.reg_b;
    assign wb_b_val  = st_q.wbb_val;

endmodule

// File: rtl/cfmt_opdec_chk.sv
module cfmt_opdec_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [3:0]    op_bytes,
    input logic          illegal,
    input logic [1:0]    mode_a,
    input logic [1:0]    mode_b,
    input logic [AW-1:0] ea_a,
    input logic [AW-1:0] ea_b,
    input logic          wb_a_en,
    input logic [2:0]    wb_a_reg,
    input logic [AW-1:0] wb_a_val,
    input logic          wb_b_en,
    input logic [2:0]    wb_b_reg,
    input logic [AW-1:0] wb_b_val
);

    p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_wb_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_a_en || wb_b_en) |-> out_valid);

    p_size_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_bytes));

    p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (illegal == (op_bytes == 4'd0)));

    p_bad_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_a_en && !wb_b_en));

    p_reg_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_a == 2'b00) |-> (ea_a == '0 && !wb_a_en));

    p_wba_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_a_en |-> (mode_a == 2'b11 && wb_a_val == ea_a + AW'(op_bytes)));

    p_wbb_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_b_en |-> (mode_b == 2'b11 && wb_b_val == ea_b + AW'(op_bytes)));

    p_one_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_a_en && wb_b_en) |-> (wb_a_reg != wb_b_reg));

endmodule

bind cfmt_opdec cfmt_opdec_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .op_bytes  (op_bytes),
    .illegal   (illegal),
    .mode_a    (mode_a),
    .mode_b    (mode_b),
    .ea_a      (ea_a),
    .ea_b      (ea_b),
    .wb_a_en   (wb_a_en),
    .wb_a_reg  (wb_a_reg),
    .wb_a_val  (wb_a_val),
    .wb_b_en   (wb_b_en),
    .wb_b_reg  (wb_b_reg),
    .wb_b_val  (wb_b_val)
);

// File: tb/cfmt_opdec_tb.sv
`timescale 1ns/1ps
module cfmt_opdec_tb;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [15:0]   insn_hw = '0;
    logic [CW-1:0] const_a = '0;
    logic [CW-1:0] const_b = '0;
    logic          wide_sel = 1'b0;
    logic [8*AW-1:0] rf_flat = '0;
    logic          out_valid, illegal, wb_a_en, wb_b_en;
    logic [5:0]    op_code;
    logic [2:0]    op_kind, reg_a, reg_b, wb_a_reg, wb_b_reg;
    logic [3:0]    op_bytes;
    logic [1:0]    mode_a, mode_b;
    logic [AW-1:0] ea_a, ea_b, wb_a_val, wb_b_val;

    int checks = 0;
    int errors = 0;

    logic [31:0] regs [8];

    // expected values
    logic        e_valid, e_bad, e_wa, e_wb;
    logic [2:0]  e_kind;
    logic [3:0]  e_bytes;
    logic [31:0] e_ea_a, e_ea_b, e_wa_val, e_wb_val;

    always #5 clk = ~clk;

    cfmt_opdec #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn_hw(insn_hw),
        .const_a(const_a), .const_b(const_b), .wide_sel(wide_sel),
        .rf_flat(rf_flat), .out_valid(out_valid), .op_code(op_code),
        .op_kind(op_kind), .op_bytes(op_bytes), .illegal(illegal),
        .mode_a(mode_a), .reg_a(reg_a), .mode_b(mode_b), .reg_b(reg_b),
        .ea_a(ea_a), .ea_b(ea_b), .wb_a_en(wb_a_en), .wb_a_reg(wb_a_reg),
        .wb_a_val(wb_a_val), .wb_b_en(wb_b_en), .wb_b_reg(wb_b_reg),
        .wb_b_val(wb_b_val)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string mtag(input logic [1:0] m, input logic [15:0] k);
        case (m)
            2'b00:   return "R4";
            2'b01:   return k[15] ? "R8" : "R7";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic addr_of(input logic [1:0] m, input logic [2:0] rs, input logic [15:0] k,
                           input logic [31:0] rg [8], input int nb,
                           output logic [31:0] ea, output logic we, output logic [31:0] wv);
        logic [31:0] idx;
        idx = (rs == 3'd0) ? 32'd0 : rg[rs];
        we  = 1'b0;
        wv  = rg[rs] + nb;
        case (m)
            2'b00: ea = 32'd0;
            2'b01: begin
                if (!k[15]) ea = idx + rg[0] + {17'd0, k[14:0]};
                else ea = idx + ((k[14:12] == 3'd0) ? 32'd0 : rg[k[14:12]]) + {20'd0, k[11:0]};
            end
            2'b10: ea = rg[rs];
            default: begin ea = rg[rs]; we = 1'b1; end
        endcase
    endtask

    task automatic model(input logic v);
        logic [31:0] rb [8];
        logic        awe, bwe;
        logic [31:0] awv;
        int          nb;
        e_valid = v;
        e_bad   = 1'b0;
        case (insn_hw[15:14])
            2'b00: begin e_kind = 3'd0; nb = 1; end
            2'b01: begin e_kind = wide_sel ? 3'd2 : 3'd1; nb = wide_sel ? 4 : 2; end
            2'b10: begin e_kind = insn_hw[13] ? 3'd4 : 3'd3; nb = insn_hw[13] ? 8 : 4; end
            default: begin e_kind = 3'd5; nb = 0; e_bad = 1'b1; end
        endcase
        e_bytes = 4'(nb);
        addr_of(insn_hw[9:8], insn_hw[7:5], const_a, regs, nb, e_ea_a, awe, awv);
        e_wa_val = awv;
        for (int i = 0; i < 8; i++) rb[i] = regs[i];
        if (awe) rb[insn_hw[7:5]] = awv;
        addr_of(insn_hw[4:3], insn_hw[2:0], const_b, rb, nb, e_ea_b, bwe, e_wb_val);
        e_wb = v && !e_bad && bwe;
        e_wa = v && !e_bad && awe && !(bwe && insn_hw[2:0] == insn_hw[7:5]);
    endtask

    task automatic drive(input logic v, input logic [15:0] hw, input logic [15:0] ka,
                         input logic [15:0] kb, input logic w);
        in_valid = v; insn_hw = hw; const_a = ka; const_b = kb; wide_sel = w;
        for (int i = 0; i < 8; i++) rf_flat[i*AW +: AW] = regs[i];
        model(v);
    endtask

    // called one negedge after drive: the output register has captured
    task automatic check_all();
        string tb_tag;
        chk("R11 out_valid", 64'(out_valid), 64'(e_valid));
        if (e_valid) begin
            chk(e_bad ? "R3 kind" : (insn_hw[15:14] == 2'b01 ? "R2 kind" : "R1 kind"),
                64'(op_kind), 64'(e_kind));
            chk(e_bad ? "R3 bytes" : "R1 bytes", 64'(op_bytes), 64'(e_bytes));
            chk("R3 illegal", 64'(illegal), 64'(e_bad));
            chk({mtag(insn_hw[9:8], const_a), " ea_a"}, 64'(ea_a), 64'(e_ea_a));
            tb_tag = (insn_hw[9:8] == 2'b11) ? "R10" : mtag(insn_hw[4:3], const_b);
            chk({tb_tag, " ea_b"}, 64'(ea_b), 64'(e_ea_b));
            if (e_wa) chk("R6 wb_a_val", 64'(wb_a_val), 64'(e_wa_val));
            if (e_wb) begin
                chk({tb_tag, " wb_b_val"}, 64'(wb_b_val), 64'(e_wb_val));
                chk("R6 wb_b_reg", 64'(wb_b_reg), 64'(insn_hw[2:0]));
            end
        end
        chk("R10 wb_a_en", 64'(wb_a_en), 64'(e_wa));
        chk("R11 wb_b_en", 64'(wb_b_en), 64'(e_wb));
    endtask

    task automatic step(input logic v, input logic [15:0] hw, input logic [15:0] ka,
                        input logic [15:0] kb, input logic w);
        drive(v, hw, ka, kb, w);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) regs[i] = 32'h1000_0000 * i + 32'h100 * i;
        for (int i = 0; i < 8; i++) rf_flat[i*AW +: AW] = regs[i];
        repeat (3) @(negedge clk);
        chk("R12 reset out_valid", 64'(out_valid), 64'd0);
        chk("R12 reset wb_a_en", 64'(wb_a_en), 64'd0);
        chk("R12 reset wb_b_en", 64'(wb_b_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 byte, register to register
        step(1'b1, {6'b000001, 2'b00, 3'd1, 2'b00, 3'd2}, 16'h0, 16'h0, 1'b0);
        // R2 halfword and word with the status bit flipped
        step(1'b1, {6'b010000, 2'b10, 3'd3, 2'b11, 3'd4}, 16'h0, 16'h0, 1'b0);
        step(1'b1, {6'b010000, 2'b10, 3'd3, 2'b11, 3'd4}, 16'h0, 16'h0, 1'b1);
        // R1 single and double float
        step(1'b1, {6'b100000, 2'b11, 3'd5, 2'b00, 3'd0}, 16'h0, 16'h0, 1'b0);
        step(1'b1, {6'b101000, 2'b11, 3'd5, 2'b00, 3'd0}, 16'h0, 16'h0, 1'b0);
        // R3 outside the format, post-increment must not write
        step(1'b1, {6'b110101, 2'b11, 3'd2, 2'b11, 3'd6}, 16'h0, 16'h0, 1'b1);
        // R7 long displacement on register 0, with index
        step(1'b1, {6'b000000, 2'b01, 3'd3, 2'b00, 3'd0}, 16'h7FFF, 16'h0, 1'b0);
        // R8 R9 zero base, no index: stays below 4096
        step(1'b1, {6'b000000, 2'b01, 3'd0, 2'b01, 3'd0}, 16'h8FFF, 16'hB123, 1'b0);
        chk("R8 R9 low window", 64'(ea_a), 64'h0FFF);
        // R10 both post-increment the same register, double size
        step(1'b1, {6'b101000, 2'b11, 3'd3, 2'b11, 3'd3}, 16'h0, 16'h0, 1'b0);
        chk("R10 shared wb", 64'(wb_b_val), 64'(regs[3] + 16));
        // R10 B indexes through A's incremented register
        step(1'b1, {6'b010000, 2'b11, 3'd0, 2'b01, 3'd0}, 16'h0, 16'h0010, 1'b1);
        chk("R10 fwd r0", 64'(ea_b), 64'(regs[0] + 4 + 16));
        // R11 idle cycle
        step(1'b0, 16'hFFFF, 16'h0, 16'h0, 1'b0);

        for (int n = 0; n < 800; n++) begin
            for (int i = 0; i < 8; i++) regs[i] = $urandom;
            step(($urandom % 5) != 0, 16'($urandom), 16'($urandom), 16'($urandom),
                 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule